// File: doc/BRIEF.md
# Page Write Buffer with NOR Programming Rules

This block models the program and erase path of a small NOR-style flash array. Software-side logic fills a page-sized write buffer one word at a time, then issues a command that commits the buffer into one page of the array. A commit can only clear bits, so each array word becomes its old value ANDed with the buffered word. Buffer slots that were never loaded hold all ones and leave their words untouched. A sector erase is the only way to bring bits back to one. It sets every word of a sector to all ones.

Each page takes one normal program between erases of its sector. A second normal program to the same page is refused and raises an error flag. A bit-field program mode skips that rule, so repeated passes can clear further bits of the same page. Program and erase hold a busy output for a fixed number of cycles, and commands or buffer loads arriving while busy is high are dropped. A registered word read port lets the array contents be checked.

Top module: `flash_page_prog`

## Requirements
- R1: After reset, busy and prog_err are low and every array word reads as all ones.
- R2: A buffer load while busy is low stores buf_wr_data at slot buf_wr_idx, and a later commit touches only the slots that were loaded. Unloaded slots are all ones and leave their words unchanged.
- R3: A commit (cmd_op 2'b00 normal program or 2'b01 bit-field program) writes old AND buffer into the page given by cmd_page. Word slot i of page p sits at word address {p, i}. No array bit ever goes from 0 to 1 by programming.
- R4: A normal program to a page that has already had a normal program since its last erase is rejected. The array is left unchanged, no busy period starts, and prog_err goes high in the cycle after the command.
- R5: prog_err keeps its value until the next accepted command and then takes that command's outcome. A command is accepted when cmd_valid is high, busy is low and cmd_op is not the reserved code 2'b11. The reserved code is ignored.
- R6: Bit-field programs may be applied to the same page any number of times, each pass clearing further bits, without raising prog_err or marking the page as programmed.
- R7: A sector erase (cmd_op 2'b10) sets every word of the sector to all ones and clears the programmed marks of its pages. The sector is the upper bits of cmd_page. Other sectors are untouched.
- R8: An accepted program or erase holds busy high for exactly BUSY_CYCLES cycles. Commands and buffer loads presented while busy is high have no effect.
- R9: rd_data shows the word at rd_addr one clock after rd_addr is presented.
- R10: Every accepted program command, including a rejected one, returns all buffer slots to all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_wr_en | input | 1 | Load one buffer slot |
| buf_wr_idx | input | 3 | Buffer slot to load |
| buf_wr_data | input | 16 | Word to place in the slot |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 program, 01 bit-field program, 10 sector erase, 11 reserved |
| cmd_page | input | 4 | Target page; its upper bits give the sector for erase |
| rd_addr | input | 7 | Word address {page, slot} for reading |
| rd_data | output | 16 | Word read, one cycle after rd_addr |
| busy | output | 1 | Program or erase in progress |
| prog_err | output | 1 | Last accepted command was a rejected reprogram |

## Verification
The commit logic is tried in several ways. Loads that cover only part of the buffer show whether unloaded slots are really all ones. Patterns that try to set bits back to one, on top of earlier clears, tell a true AND apart from an overwrite. Sequences that repeat a normal program, repeat a bit-field program, erase and then program again, or issue a command during busy separate the program-once rule from the bit-field exemption and from the busy lockout. A seeded random mix of loads, commands and reads over all pages and sectors, followed by a scan of the whole array, shows whether erase or program ever reaches past its own sector or page.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
   typedef enum logic [1:0] {
      OP_PROG  = 2'b00,
      OP_BITF  = 2'b01,
      OP_ERASE = 2'b10,
      OP_NONE  = 2'b11
   } fpp_op_e;
endpackage

// File: rtl/fpp_wbuf.sv
module fpp_wbuf #(
   parameter int DATA_W     = 16,
   parameter int PAGE_WORDS = 8,
   localparam int IDX_W     = $clog2(PAGE_WORDS)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [IDX_W-1:0]                    wr_idx,
   input  logic [DATA_W-1:0]                   wr_data,
   input  logic                                clr,
   output logic [PAGE_WORDS-1:0][DATA_W-1:0]   words
);
   // each slot is an independent register; clear wins over a load
   for (genvar s = 0; s < PAGE_WORDS; s++) begin : g_slot
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr)
            q <= '1;
         else if (wr_en && wr_idx == IDX_W'(s))
            q <= wr_data;
      end
      assign words[s] = q;
   end
endmodule

// File: rtl/fpp_ctrl.sv
module fpp_ctrl #(
   parameter int PAGES_PER_SEC = 4,
   parameter int NUM_SECTORS   = 4,
   parameter int BUSY_CYCLES   = 4,
   localparam int SEC_W        = $clog2(NUM_SECTORS),
   localparam int PG_W         = $clog2(PAGES_PER_SEC) + SEC_W,
   localparam int NUM_PAGES    = PAGES_PER_SEC * NUM_SECTORS,
   localparam int CNT_W        = $clog2(BUSY_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic [PG_W-1:0]  cmd_page,
   output logic             busy,
   output logic             prog_err,
   output logic             do_prog,
   output logic             do_erase,
   output logic             buf_clr,
   output logic [SEC_W-1:0] tgt_sec
);
   import fpp_pkg::*;

   logic [CNT_W-1:0]     cnt_q;
   logic [NUM_PAGES-1:0] done_q;
   fpp_op_e              op;
   logic                 accept, is_prog, reject;

   assign op      = fpp_op_e'(cmd_op);
   assign busy    = (cnt_q != '0);
   assign accept  = cmd_valid && !busy && (op != OP_NONE);
   assign is_prog = (op == OP_PROG) || (op == OP_BITF);
   assign reject  = accept && (op == OP_PROG) && done_q[cmd_page];
   assign do_prog = accept && is_prog && !reject;
   assign do_erase = accept && (op == OP_ERASE);
   assign buf_clr = accept && is_prog;
   assign tgt_sec = cmd_page[PG_W-1 -: SEC_W];

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (do_prog || do_erase)
         cnt_q <= CNT_W'(BUSY_CYCLES);
      else if (busy)
         cnt_q <= cnt_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         prog_err <= 1'b0;
      else if (accept)
         prog_err <= reject;
   end

   // one program-once mark per page
   for (genvar p = 0; p < NUM_PAGES; p++) begin : g_mark
      localparam int SEC = p / PAGES_PER_SEC;
      always_ff @(posedge clk) begin
         if (!rst_n)
            done_q[p] <= 1'b0;
         else if (do_erase && tgt_sec == SEC_W'(SEC))
            done_q[p] <= 1'b0;
         else if (do_prog && op == OP_PROG && cmd_page == PG_W'(p))
            done_q[p] <= 1'b1;
      end
   end
endmodule

// File: rtl/fpp_array.sv
module fpp_array #(
   parameter int DATA_W        = 16,
   parameter int PAGE_WORDS    = 8,
   parameter int PAGES_PER_SEC = 4,
   parameter int NUM_SECTORS   = 4,
   parameter bit REG_READ      = 1'b1,
   localparam int IDX_W        = $clog2(PAGE_WORDS),
   localparam int SEC_W        = $clog2(NUM_SECTORS),
   localparam int PG_W         = $clog2(PAGES_PER_SEC) + SEC_W,
   localparam int ADDR_W       = PG_W + IDX_W,
   localparam int NUM_WORDS    = PAGE_WORDS * PAGES_PER_SEC * NUM_SECTORS
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              prog_en,
   input  logic                              erase_en,
   input  logic [PG_W-1:0]                   prog_page,
   input  logic [SEC_W-1:0]                  erase_sec,
   input  logic [PAGE_WORDS-1:0][DATA_W-1:0] pdata,
   input  logic [ADDR_W-1:0]                 rd_addr,
   output logic [DATA_W-1:0]                 rd_data
);
   logic [DATA_W-1:0] cells [NUM_WORDS];

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam int PG  = w / PAGE_WORDS;
      localparam int OFF = w % PAGE_WORDS;
      localparam int SEC = PG / PAGES_PER_SEC;
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '1;
         else if (erase_en && erase_sec == SEC_W'(SEC))
            q <= '1;
         else if (prog_en && prog_page == PG_W'(PG))
            q <= q & pdata[OFF];
      end
      assign cells[w] = q;
   end

   if (REG_READ) begin : g_rd_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            rd_q <= '1;
         else
            rd_q <= cells[rd_addr];
      end
      assign rd_data = rd_q;
   end else begin : g_rd_comb
      assign rd_data = cells[rd_addr];
   end
endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog #(
   parameter int DATA_W        = 16,
   parameter int PAGE_WORDS    = 8,
   parameter int PAGES_PER_SEC = 4,
   parameter int NUM_SECTORS   = 4,
   parameter int BUSY_CYCLES   = 4,
   parameter bit REG_READ      = 1'b1,
   localparam int IDX_W        = $clog2(PAGE_WORDS),
   localparam int SEC_W        = $clog2(NUM_SECTORS),
   localparam int PG_W         = $clog2(PAGES_PER_SEC) + SEC_W,
   localparam int ADDR_W       = PG_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              buf_wr_en,
   input  logic [IDX_W-1:0]  buf_wr_idx,
   input  logic [DATA_W-1:0] buf_wr_data,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [PG_W-1:0]   cmd_page,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              prog_err
);
   if (DATA_W < 1) begin : g_bad_w
      $error("DATA_W must be at least 1");
   end
   if (PAGE_WORDS < 2 || (PAGE_WORDS & (PAGE_WORDS - 1)) != 0) begin : g_bad_pw
      $error("PAGE_WORDS must be a power of two, at least 2");
   end
   if (PAGES_PER_SEC < 2 || (PAGES_PER_SEC & (PAGES_PER_SEC - 1)) != 0) begin : g_bad_ps
      $error("PAGES_PER_SEC must be a power of two, at least 2");
   end
   if (NUM_SECTORS < 2 || (NUM_SECTORS & (NUM_SECTORS - 1)) != 0) begin : g_bad_ns
      $error("NUM_SECTORS must be a power of two, at least 2");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_bc
      $error("BUSY_CYCLES must be at least 1");
   end

   logic [PAGE_WORDS-1:0][DATA_W-1:0] buf_words;
   logic                              do_prog, do_erase, buf_clr;
   logic [SEC_W-1:0]                  tgt_sec;

   fpp_ctrl #(
      .PAGES_PER_SEC (PAGES_PER_SEC),
      .NUM_SECTORS   (NUM_SECTORS),
      .BUSY_CYCLES   (BUSY_CYCLES)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_page  (cmd_page),
      .busy      (busy),
      .prog_err  (prog_err),
      .do_prog   (do_prog),
      .do_erase  (do_erase),
      .buf_clr   (buf_clr),
      .tgt_sec   (tgt_sec)
   );

   fpp_wbuf #(
      .DATA_W     (DATA_W),
      .PAGE_WORDS (PAGE_WORDS)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (buf_wr_en && !busy),
      .wr_idx  (buf_wr_idx),
      .wr_data (buf_wr_data),
      .clr     (buf_clr),
      .words   (buf_words)
   );

   fpp_array #(
      .DATA_W        (DATA_W),
      .PAGE_WORDS    (PAGE_WORDS),
      .PAGES_PER_SEC (PAGES_PER_SEC),
      .NUM_SECTORS   (NUM_SECTORS),
      .REG_READ      (REG_READ)
   ) u_arr (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog_en   (do_prog),
      .erase_en  (do_erase),
      .prog_page (cmd_page),
      .erase_sec (tgt_sec),
      .pdata     (buf_words),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data)
   );
endmodule

// File: rtl/fpp_chk.sv
module fpp_chk #(
   parameter int DATA_W      = 16,
   parameter int PAGE_WORDS  = 8,
   parameter int BUSY_CYCLES = 4,
   localparam int IDX_W      = $clog2(PAGE_WORDS)
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              cmd_valid,
   input logic [1:0]                        cmd_op,
   input logic                              busy,
   input logic                              prog_err,
   input logic                              buf_wr_en,
   input logic [IDX_W-1:0]                  buf_wr_idx,
   input logic [DATA_W-1:0]                 buf_wr_data,
   input logic                              buf_clr,
   input logic [PAGE_WORDS-1:0][DATA_W-1:0] buf_words
);
   logic [31:0] run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         run_q <= '0;
      else if (busy)
         run_q <= run_q + 1;
      else
         run_q <= '0;
   end

   p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= 32'(BUSY_CYCLES));

   p_erase_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && cmd_op == 2'b10) |=> busy);

   p_busy_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !prog_err) |=> !prog_err);

   p_err_rise_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_err) |-> !busy);

   p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> $stable(prog_err));

   p_buf_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_wr_en && !busy && !buf_clr) |=>
         buf_words[$past(buf_wr_idx)] == $past(buf_wr_data));

   p_buf_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      buf_clr |=> (buf_words == '1));
endmodule

bind flash_page_prog fpp_chk #(
   .DATA_W      (DATA_W),
   .PAGE_WORDS  (PAGE_WORDS),
   .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_op      (cmd_op),
   .busy        (busy),
   .prog_err    (prog_err),
   .buf_wr_en   (buf_wr_en),
   .buf_wr_idx  (buf_wr_idx),
   .buf_wr_data (buf_wr_data),
   .buf_clr     (buf_clr),
   .buf_words   (buf_words)
);

// File: tb/flash_page_prog_tb_top.sv
module flash_page_prog_tb_top;
   localparam int W    = 16;
   localparam int PW   = 8;
   localparam int PPS  = 4;
   localparam int NS   = 4;
   localparam int BC   = 4;
   localparam int NPG  = PPS * NS;
   localparam int NWD  = NPG * PW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          buf_wr_en = 1'b0;
   logic [2:0]    buf_wr_idx = '0;
   logic [W-1:0]  buf_wr_data = '0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'b11;
   logic [3:0]    cmd_page = '0;
   logic [6:0]    rd_addr = '0;
   logic [W-1:0]  rd_data;
   logic          busy, prog_err;

   always #5 clk = ~clk;

   flash_page_prog #(
      .DATA_W(W), .PAGE_WORDS(PW), .PAGES_PER_SEC(PPS),
      .NUM_SECTORS(NS), .BUSY_CYCLES(BC), .REG_READ(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .buf_wr_en(buf_wr_en), .buf_wr_idx(buf_wr_idx),
      .buf_wr_data(buf_wr_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_page(cmd_page), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy), .prog_err(prog_err)
   );

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [W-1:0] exp_mem [NWD];
   logic [W-1:0] exp_buf [PW];
   bit           exp_mark [NPG];
   bit           exp_err;

   function automatic void model_reset();
      for (int i = 0; i < NWD; i++) exp_mem[i] = '1;
      for (int i = 0; i < PW; i++) exp_buf[i] = '1;
      for (int i = 0; i < NPG; i++) exp_mark[i] = 1'b0;
      exp_err = 1'b0;
   endfunction

   // expected outcome of an accepted command; returns 1 when busy should start
   function automatic bit model_cmd(input logic [1:0] op, input int pg);
      bit starts = 1'b0;
      if (op == 2'b00 || op == 2'b01) begin
         if (op == 2'b00 && exp_mark[pg]) begin
            exp_err = 1'b1;
         end else begin
            for (int i = 0; i < PW; i++)
               exp_mem[pg*PW + i] = exp_mem[pg*PW + i] & exp_buf[i];
            if (op == 2'b00) exp_mark[pg] = 1'b1;
            exp_err = 1'b0;
            starts = 1'b1;
         end
         for (int i = 0; i < PW; i++) exp_buf[i] = '1;
      end else if (op == 2'b10) begin
         for (int p = 0; p < NPG; p++)
            if (p / PPS == pg / PPS) begin
               exp_mark[p] = 1'b0;
               for (int i = 0; i < PW; i++) exp_mem[p*PW + i] = '1;
            end
         exp_err = 1'b0;
         starts = 1'b1;
      end
      return starts;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic load(input int idx, input logic [W-1:0] d);
      buf_wr_en = 1'b1; buf_wr_idx = 3'(idx); buf_wr_data = d;
      @(negedge clk);
      buf_wr_en = 1'b0;
      exp_buf[idx] = d;
   endtask

   task automatic issue(input logic [1:0] op, input int pg, input string req);
      bit starts;
      int n = 0;
      cmd_valid = 1'b1; cmd_op = op; cmd_page = 4'(pg);
      @(negedge clk);
      cmd_valid = 1'b0;
      starts = model_cmd(op, pg);
      while (busy && n < 100) begin
         n++;
         @(negedge clk);
      end
      check(n == (starts ? BC : 0), "R8", "busy length", 32'(n), 32'(starts ? BC : 0));
      check(prog_err == exp_err, req, "prog_err", 32'(prog_err), 32'(exp_err));
   endtask

   task automatic rd(input int a, input string req);
      rd_addr = 7'(a);
      @(negedge clk);
      check(rd_data == exp_mem[a], req, $sformatf("word %0d", a), 32'(rd_data), 32'(exp_mem[a]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int unsigned sd;
      sd = $urandom(32'd4242);
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(!busy, "R1", "busy after reset", 32'(busy), 0);
      check(!prog_err, "R1", "prog_err after reset", 32'(prog_err), 0);
      rd(0, "R1"); rd(NWD-1, "R1"); rd(77, "R9");

      // R2/R3: partial load, normal program of page 3
      load(2, 16'h1234);
      issue(2'b00, 3, "R3");
      rd(3*PW + 2, "R3"); rd(3*PW + 0, "R2"); rd(3*PW + 7, "R2");

      // R4: second normal program of page 3 rejected
      load(2, 16'h0000);
      issue(2'b00, 3, "R4");
      check(prog_err, "R4", "reject flag", 32'(prog_err), 1);
      rd(3*PW + 2, "R4");

      // R5: reserved op leaves flag; R6: bit-field passes allowed
      issue(2'b11, 0, "R5");
      check(prog_err, "R5", "flag kept on reserved op", 32'(prog_err), 1);
      load(2, 16'hF0F0);
      issue(2'b01, 3, "R6");
      check(!prog_err, "R5", "flag cleared by accepted cmd", 32'(prog_err), 0);
      rd(3*PW + 2, "R6");
      load(2, 16'hFFFF); load(5, 16'h00FF);
      issue(2'b01, 3, "R6");
      rd(3*PW + 2, "R3"); rd(3*PW + 5, "R6");

      // R10: a program with no loads after a commit changes nothing
      issue(2'b01, 5, "R10");
      rd(5*PW + 0, "R10"); rd(5*PW + 6, "R10");

      // R8: commands and loads during busy are dropped; R7: erase clears marks
      cmd_valid = 1'b1; cmd_op = 2'b10; cmd_page = 4'd1;
      @(negedge clk);
      cmd_valid = 1'b0;
      void'(model_cmd(2'b10, 1));
      check(busy, "R8", "busy after erase", 32'(busy), 1);
      buf_wr_en = 1'b1; buf_wr_idx = 3'd0; buf_wr_data = 16'h0000;
      @(negedge clk);
      buf_wr_en = 1'b0;
      cmd_valid = 1'b1; cmd_op = 2'b00; cmd_page = 4'd7;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (busy) @(negedge clk);
      check(!prog_err, "R8", "cmd during busy ignored", 32'(prog_err), 0);
      rd(3*PW + 2, "R7"); rd(7*PW + 0, "R8");
      issue(2'b01, 1, "R8");
      rd(1*PW + 0, "R8");
      load(4, 16'hA5A5);
      issue(2'b00, 3, "R7");
      rd(3*PW + 4, "R7");

      // R7: erase of sector 1 leaves sector 0
      load(1, 16'h0F0F);
      issue(2'b00, 0, "R7");
      issue(2'b10, 6, "R7");
      rd(0*PW + 1, "R7"); rd(3*PW + 4, "R7");

      // random mix
      for (int it = 0; it < 400; it++) begin
         int nl = $urandom_range(0, 3);
         for (int k = 0; k < nl; k++)
            load($urandom_range(0, PW-1), W'($urandom) | W'($urandom));
         issue(2'($urandom_range(0, 3)), $urandom_range(0, NPG-1), "R3");
         for (int k = 0; k < 2; k++) rd($urandom_range(0, NWD-1), "R3");
      end

      for (int a = 0; a < NWD; a++) rd(a, "R7");

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule